// File: doc/BRIEF.md
# Sticky Interrupt Status Block with Latch and Signal Masks

This block holds the normal interrupt status of a storage-card host controller. Single-cycle event pulses from the command, data and DMA engines set sticky bits in a status register. A bit only latches if its bit in a latch-enable mask is set. Software clears a bit by writing a one to it. A second, independent mask selects which latched bits drive the single interrupt line.

The upper half of the status word carries error causes. One bit in the lower half (bit 15 by default) is not stored. It reads as the OR of all latched error bits, so software tests a single bit to see whether any error is pending. The bit assignments used are: 0 command done, 1 transfer done, 3 DMA stop, 4 write buffer ready, 5 read buffer ready, 15 error summary, and 16 command timeout. Apart from bit 15, the block treats all bits alike.

Three registers sit behind a small word-wide port. Address 0 is the status word, address 1 the latch-enable mask and address 2 the signal-enable mask. Reads are combinational.

Top module: `int_status_ctl`

## Requirements
- R1: After reset, the status word, the latch-enable mask and the signal-enable mask all read 0, and `irq_o` is low.
- R2: An `evt_i[i]` pulse while latch-enable bit i is set makes status bit i read 1 from the next cycle on. The bit stays 1 after the pulse ends. This holds for every bit except bit 15.
- R3: An `evt_i[i]` pulse while latch-enable bit i is clear leaves status bit i unchanged.
- R4: A write to address 0 clears each status bit whose write-data bit is 1 and leaves the bits whose write-data bit is 0 unchanged.
- R5: If a latching event and a clearing write hit the same status bit in the same cycle, the bit reads 1 afterwards.
- R6: Status bit 15 always reads as the OR of status bits 31:16. Writes to bit 15 and events on bit 15 have no effect on it.
- R7: `irq_o` is high exactly when some bit of the status word, as read, is also set in the signal-enable mask. The masks at addresses 1 and 2 read back the last value written.
- R8: A write to the latch-enable mask takes effect for events from the next cycle on. An event in the same cycle as the write uses the old mask. Clearing a mask bit does not clear a bit that is already latched.
- R9: Address 3 reads 0, and writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 status, 1 latch mask, 2 signal mask |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Interrupt line |

## Verification
Two kinds of same-cycle collision matter. The first is an event arriving on the same edge as a write-one clear of that bit, where the event must win. The second is an event arriving on the same edge as a write to the latch-enable mask, where the old mask must govern. The bench creates both by driving the event pulse and the write strobe in the same cycle. It then judges the status word one cycle later against a behavioural model that it steps on every clock. A random phase repeats these collisions over many cycles with dense event and write traffic.

// File: rtl/int_stat_pkg.sv
package int_stat_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_LEN  = 2'd1,
    REG_SEN  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/int_en_reg.sv
module int_en_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (we_i) q_q <= d_i;
  end

  assign q_o = q_q;

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/int_stat_bits.sv
module int_stat_bits #(
  parameter int W       = 32,
  parameter int SUM_BIT = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] len_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  localparam logic [W-1:0] LIVE = ~({{(W-1){1'b0}}, 1'b1} << SUM_BIT);

  logic [W-1:0] set_v;
  logic [W-1:0] stat_q;

  assign set_v = evt_i & len_i & LIVE;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == SUM_BIT) begin : g_sum
      // summary position is derived elsewhere, never stored
      assign stat_q[i] = 1'b0;
    end else begin : g_cell
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       stat_q[i] <= 1'b0;
        else if (set_v[i]) stat_q[i] <= 1'b1; // event beats clear
        else if (clr_i[i]) stat_q[i] <= 1'b0;
      end
    end
  end

  assign stat_o = stat_q;

  p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_v) |=> ((stat_o & $past(set_v)) == $past(set_v)));
  p_no_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(set_v)) == '0));
  p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_v)) |=> ((stat_o & $past(clr_i & ~set_v)) == '0));
  p_evt_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & set_v)) |=> ((stat_o & $past(clr_i & set_v)) == $past(clr_i & set_v)));
endmodule

// File: rtl/int_irq_gen.sv
module int_irq_gen #(
  parameter int W       = 32,
  parameter int SUM_BIT = 15
) (
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] sen_i,
  output logic [W-1:0] view_o,
  output logic         irq_o
);
  localparam int ERR_LO = SUM_BIT + 1;

  logic err_any;

  assign err_any = |stat_i[W-1:ERR_LO];

  always_comb begin
    view_o          = stat_i;
    view_o[SUM_BIT] = err_any;
  end

  assign irq_o = |(view_o & sen_i);

  always_comb begin
    if (irq_o) p_irq_src_r7: assert (stat_i != '0);
  end
endmodule

// File: rtl/int_status_ctl.sv
module int_status_ctl
  import int_stat_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SUM_BIT = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int ERR_LO = SUM_BIT + 1;

  reg_sel_e          sel;
  logic              we_stat, we_len, we_sen;
  logic [DATA_W-1:0] clr_v, len_q, sen_q, stat_q, view;

  assign sel     = reg_sel_e'(addr_i);
  assign we_stat = wr_en_i && (sel == REG_STAT);
  assign we_len  = wr_en_i && (sel == REG_LEN);
  assign we_sen  = wr_en_i && (sel == REG_SEN);
  assign clr_v   = we_stat ? wdata_i : '0;

  int_en_reg #(.W(DATA_W)) u_len (
    .clk_i (clk_i), .rst_ni(rst_ni), .we_i(we_len), .d_i(wdata_i), .q_o(len_q)
  );

  int_en_reg #(.W(DATA_W)) u_sen (
    .clk_i (clk_i), .rst_ni(rst_ni), .we_i(we_sen), .d_i(wdata_i), .q_o(sen_q)
  );

  int_stat_bits #(.W(DATA_W), .SUM_BIT(SUM_BIT)) u_stat (
    .clk_i (clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .len_i(len_q),
    .clr_i (clr_v), .stat_o(stat_q)
  );

  int_irq_gen #(.W(DATA_W), .SUM_BIT(SUM_BIT)) u_irq (
    .stat_i(stat_q), .sen_i(sen_q), .view_o(view), .irq_o(irq_o)
  );

  always_comb begin
    unique case (sel)
      REG_STAT: rdata_o = view;
      REG_LEN:  rdata_o = len_q;
      REG_SEN:  rdata_o = sen_q;
      default:  rdata_o = '0;
    endcase
  end

  p_sum_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(view[SUM_BIT]) |-> $past(|(evt_i[DATA_W-1:ERR_LO] & len_q[DATA_W-1:ERR_LO])));
  p_old_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_len && (stat_q == '0) && ((evt_i & len_q) == '0)) |=> (stat_q == '0));
  p_dead_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == REG_NONE) |=> ($stable(len_q) && $stable(sen_q)));
endmodule

// File: tb/int_status_ctl_tb_top.sv
module int_status_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] evt_i = '0;
  logic         wr_en_i = 1'b0;
  logic [1:0]   addr_i = 2'd0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o;
  logic         irq_o;

  int n_chk = 0;
  int n_bad = 0;
  string phase = "R1";

  // behavioural reference state
  bit [W-1:0] m_stat, m_len, m_sen;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_status_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic bit [W-1:0] m_view();
    bit [W-1:0] v;
    v = m_stat;
    v[15] = (m_stat[31:16] != 0);
    return v;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_stat <= 0; m_len <= 0; m_sen <= 0;
    end else begin
      bit [W-1:0] nxt;
      nxt = m_stat;
      for (int i = 0; i < W; i++) begin
        if (i == 15) continue;
        if (wr_en_i && addr_i == 2'd0 && wdata_i[i]) nxt[i] = 1'b0;
        if (evt_i[i] && m_len[i]) nxt[i] = 1'b1;
      end
      m_stat <= nxt;
      if (wr_en_i && addr_i == 2'd1) m_len <= wdata_i;
      if (wr_en_i && addr_i == 2'd2) m_sen <= wdata_i;
    end
  end

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    bit [W-1:0] e;
    case (addr_i)
      2'd0: e = m_view();
      2'd1: e = m_len;
      2'd2: e = m_sen;
      default: e = 0;
    endcase
    chk(phase, rdata_o, e);
    chk({phase, " irq"}, {31'd0, irq_o}, {31'd0, (m_view() & m_sen) != 0});
  endtask

  // drive at negedge, state moves at posedge, judge at the following negedge
  task automatic step(bit [W-1:0] ev, bit we, bit [1:0] a, bit [W-1:0] d);
    evt_i = ev; wr_en_i = we; addr_i = a; wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    evt_i = '0; wr_en_i = 1'b0;
    compare();
  endtask

  task automatic rd(bit [1:0] a);
    step('0, 1'b0, a, '0);
  endtask

  bit done = 0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    phase = "R1";
    chk("R1 reset status", rdata_o, '0);
    chk("R1 reset irq", {31'd0, irq_o}, '0);
    rst_ni = 1'b1;
    rd(2'd0); rd(2'd1); rd(2'd2);
    chk("R1 sen zero", rdata_o, '0);

    phase = "R3";
    step('1, 1'b0, 2'd0, '0);
    chk("R3 masked event", rdata_o, '0);

    phase = "R8";
    step('1, 1'b1, 2'd1, 32'h000F_803B);
    rd(2'd0);
    chk("R8 old mask applied", rdata_o, '0);

    phase = "R2";
    step(32'h0000_0009, 1'b0, 2'd0, '0);
    chk("R2 bits 0 and 3", rdata_o, 32'h0000_0009);
    rd(2'd0); rd(2'd0);
    chk("R2 sticky", rdata_o, 32'h0000_0009);

    phase = "R4";
    step('0, 1'b1, 2'd0, 32'h0000_0001);
    chk("R4 clear bit 0 only", rdata_o, 32'h0000_0008);
    step('0, 1'b1, 2'd0, 32'h0000_0000);
    chk("R4 zero write", rdata_o, 32'h0000_0008);

    phase = "R5";
    step(32'h0000_0002, 1'b1, 2'd0, 32'h0000_000A);
    chk("R5 event wins", rdata_o, 32'h0000_0002);

    phase = "R6";
    step(32'h0001_8000, 1'b0, 2'd0, '0);
    chk("R6 summary set", rdata_o, 32'h0001_8002);
    step('0, 1'b1, 2'd0, 32'h0000_8000);
    chk("R6 write to summary ignored", rdata_o, 32'h0001_8002);
    step('0, 1'b1, 2'd0, 32'h0001_0000);
    chk("R6 summary follows", rdata_o, 32'h0000_0002);
    step(32'h0000_8000, 1'b0, 2'd0, '0);
    chk("R6 event on summary ignored", rdata_o, 32'h0000_0002);

    phase = "R7";
    step('0, 1'b1, 2'd2, 32'h0000_0002);
    chk("R7 irq on transfer done", {31'd0, irq_o}, 32'd1);
    chk("R7 sen readback", rdata_o, 32'h0000_0002);
    step('0, 1'b1, 2'd2, 32'h0000_8000);
    chk("R7 irq off", {31'd0, irq_o}, 32'd0);
    step(32'h0002_0000, 1'b0, 2'd0, '0);
    chk("R7 irq via summary", {31'd0, irq_o}, 32'd1);

    phase = "R8";
    step('0, 1'b1, 2'd1, 32'h0000_0000);
    rd(2'd0);
    chk("R8 latched kept", rdata_o, 32'h0002_8002);

    phase = "R9";
    step('0, 1'b1, 2'd3, 32'hFFFF_FFFF);
    chk("R9 dead address", rdata_o, '0);
    rd(2'd2);
    chk("R9 sen intact", rdata_o, 32'h0000_8000);

    phase = "R5 random";
    for (int k = 0; k < 3000; k++) begin
      bit [W-1:0] ev;
      ev = $urandom & $urandom;
      step(ev, ($urandom % 3) != 0, 2'($urandom), $urandom);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule